// File: doc/BRIEF.md
# Serial Slave Shift Engine with Fault Flags

This block is the receive and transmit core of a synchronous serial slave. An outside master drives the shift clock, the data input and an active-low select line. The block samples one data bit on each rising shift-clock edge and moves its shift register on each falling edge. It returns its transmit word on the data output, most significant bit first. At the end of each frame the received word goes into a receive register, and a one-cycle valid strobe marks it.

Two protocol faults are monitored. A phase fault is raised when the data input moves too close to the latching edge. A transmit fault is raised when a master starts a frame before new transmit data has been written. In that case the slave sends out the word it holds in its shift register, which is normally the word it received in the previous frame. Each fault sets its own sticky flag in every case. A shared interrupt line reports only the flags whose enable input is high.

The engine is a three-state machine. `ST_IDLE` means deselected. `ST_READY` means selected and waiting for the first rising edge. `ST_SHIFT` means a frame is in progress.
- IDLE→READY when select goes active.
- READY→SHIFT on the first rising edge. The transmit-fault test is made on this edge.
- SHIFT→READY on the last falling edge of the frame.
- READY→IDLE and SHIFT→IDLE when select is released. Leaving SHIFT this way aborts the frame.

Top module: `spi_slave_err`

## Requirements
- R1: After reset the flags, the interrupt, busy, the valid strobe and the receive word are all 0. The data output is 0 while the slave is deselected.
- R2: After FRAME_W rising/falling shift-clock pairs, rx_data holds the bits sampled on the rising edges, first bit in the MSB. rx_valid pulses once for the frame, for exactly one cycle.
- R3: A word written through tb_we/tb_wdata while no frame is running is driven on miso MSB first. Each bit is valid before its rising edge.
- R4: busy is 0 while the slave waits for a frame. It is 1 from the first rising edge until the final falling edge of the frame.
- R5: A write while busy is high queues that word. The next frame sends it and raises no transmit fault.
- R6: When a frame starts with no write since the previous frame, te_flag is set and miso sends the word received in the previous frame.
- R7: pe_flag is set when, on the synchronized signals, mosi changes from one system clock before to two system clocks after a rising shift-clock edge while selected. Changes two or more clocks before the edge, or three or more clocks after it, do not set the flag.
- R8: Both flags stay set until err_clr is pulsed. A pulse clears them.
- R9: err_irq is high exactly when some flag is set and its enable is high. The flags set whatever the enables are.
- R10: Releasing select in mid-frame aborts the frame: busy falls, no rx_valid is produced, and the next frame starts from bit one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Shift clock from the master (idle low) |
| mosi_in | input | 1 | Serial data from the master |
| ssn_in | input | 1 | Active-low slave select |
| miso_out | output | 1 | Serial data to the master, 0 when deselected |
| tb_we | input | 1 | Transmit word write strobe |
| tb_wdata | input | FRAME_W | Transmit word |
| rx_data | output | FRAME_W | Last received word |
| rx_valid | output | 1 | One-cycle strobe for a new received word |
| busy | output | 1 | Frame in progress |
| pe_en | input | 1 | Phase fault interrupt enable |
| te_en | input | 1 | Transmit fault interrupt enable |
| err_clr | input | 1 | Clears both fault flags |
| pe_flag | output | 1 | Sticky phase fault flag |
| te_flag | output | 1 | Sticky transmit fault flag |
| err_irq | output | 1 | Shared fault interrupt |

## Verification
Every pin first passes through two synchronizing flops. The state and data registers then act on the next edge, so busy, the shift register (and with it miso), rx_data and the flags change three system clocks after the pin that caused the change. A transmit word needs two clocks to reach miso. The bench holds each shift-clock level for eight system clocks and samples only at the end of each level, well after every result is due. The phase sweep moves one mosi transition from four clocks before to five clocks after a rising edge. It reads the flag ten clocks later, which places the edge of the window exactly.

// File: rtl/sps_pkg.sv
package sps_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READY = 2'd1,
        ST_SHIFT = 2'd2
    } sps_state_e;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
    parameter int          N       = 3,
    parameter int          STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    for (genvar b = 0; b < N; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
            else        chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/sps_phase_mon.sv
module sps_phase_mon (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic mosi_s,
    input  logic sel,
    output logic rise,
    output logic fall,
    output logic pe_evt
);
    logic sclk_q, mosi_q;
    logic chg, chg_d1, rise_d1, rise_d2;

    assign rise = sclk_s & ~sclk_q;
    assign fall = ~sclk_s & sclk_q;
    assign chg  = mosi_s ^ mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q  <= 1'b0;
            mosi_q  <= 1'b0;
            chg_d1  <= 1'b0;
            rise_d1 <= 1'b0;
            rise_d2 <= 1'b0;
        end else begin
            sclk_q  <= sclk_s;
            mosi_q  <= mosi_s;
            chg_d1  <= chg;
            rise_d1 <= rise;
            rise_d2 <= rise_d1;
        end
    end

    // window: change at edge-1, edge, edge+1, edge+2
    assign pe_evt = sel & ((rise & (chg | chg_d1)) | (chg & (rise_d1 | rise_d2)));
endmodule

// File: rtl/sps_engine.sv
module sps_engine
    import sps_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic               rise,
    input  logic               fall,
    input  logic               mosi_bit,
    input  logic               tb_we,
    input  logic [FRAME_W-1:0] tb_wdata,
    output logic               miso,
    output logic [FRAME_W-1:0] rx_data,
    output logic               rx_valid,
    output logic               te_evt,
    output sps_state_e         state
);
    localparam int CNT_W = (FRAME_W > 2) ? $clog2(FRAME_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    sps_state_e         nxt;
    logic [FRAME_W-1:0] sreg, tbuf, shifted;
    logic [CNT_W-1:0]   cnt;
    logic               samp, tb_full, fresh, last;

    assign last    = (cnt == LAST);
    assign shifted = {sreg[FRAME_W-2:0], samp};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (sel) nxt = ST_READY;
            ST_READY: begin
                if (!sel)      nxt = ST_IDLE;
                else if (rise) nxt = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (!sel)              nxt = ST_IDLE;
                else if (fall && last) nxt = ST_READY;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    assign te_evt = (state == ST_READY) && sel && rise && !fresh;
    assign miso   = sel & sreg[FRAME_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg     <= '0;
            tbuf     <= '0;
            rx_data  <= '0;
            cnt      <= '0;
            samp     <= 1'b0;
            tb_full  <= 1'b0;
            fresh    <= 1'b0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (tb_we) begin
                tbuf    <= tb_wdata;
                tb_full <= 1'b1;
            end
            unique case (state)
                ST_IDLE, ST_READY: begin
                    if (state == ST_READY && sel && rise) begin
                        samp  <= mosi_bit;
                        fresh <= 1'b0;
                        cnt   <= '0;
                    end else if (tb_full) begin
                        sreg  <= tbuf;
                        fresh <= 1'b1;
                        if (!tb_we) tb_full <= 1'b0;
                    end
                end
                ST_SHIFT: begin
                    if (!sel) begin
                        cnt <= '0;
                    end else begin
                        if (rise) samp <= mosi_bit;
                        if (fall) begin
                            sreg <= shifted;
                            if (last) begin
                                rx_data  <= shifted;
                                rx_valid <= 1'b1;
                                cnt      <= '0;
                                if (tb_full) begin
                                    sreg  <= tbuf;
                                    fresh <= 1'b1;
                                    if (!tb_we) tb_full <= 1'b0;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sps_flags.sv
module sps_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic pe_evt,
    input  logic te_evt,
    input  logic err_clr,
    input  logic pe_en,
    input  logic te_en,
    output logic pe_flag,
    output logic te_flag,
    output logic err_irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pe_flag <= 1'b0;
            te_flag <= 1'b0;
        end else begin
            if (pe_evt)       pe_flag <= 1'b1;
            else if (err_clr) pe_flag <= 1'b0;
            if (te_evt)       te_flag <= 1'b1;
            else if (err_clr) te_flag <= 1'b0;
        end
    end

    assign err_irq = (pe_flag & pe_en) | (te_flag & te_en);
endmodule

// File: rtl/spi_slave_err.sv
module spi_slave_err
    import sps_pkg::*;
#(
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_in,
    input  logic               mosi_in,
    input  logic               ssn_in,
    output logic               miso_out,
    input  logic               tb_we,
    input  logic [FRAME_W-1:0] tb_wdata,
    output logic [FRAME_W-1:0] rx_data,
    output logic               rx_valid,
    output logic               busy,
    input  logic               pe_en,
    input  logic               te_en,
    input  logic               err_clr,
    output logic               pe_flag,
    output logic               te_flag,
    output logic               err_irq
);
    logic [2:0] pins_s;
    logic       sel, rise, fall, pe_evt, te_evt;
    sps_state_e st;

    sps_sync #(.N(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ssn_in, mosi_in, sclk_in}),
        .q     (pins_s)
    );

    assign sel = ~pins_s[2];

    sps_phase_mon u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (pins_s[0]),
        .mosi_s (pins_s[1]),
        .sel    (sel),
        .rise   (rise),
        .fall   (fall),
        .pe_evt (pe_evt)
    );

    sps_engine #(.FRAME_W(FRAME_W)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .rise     (rise),
        .fall     (fall),
        .mosi_bit (pins_s[1]),
        .tb_we    (tb_we),
        .tb_wdata (tb_wdata),
        .miso     (miso_out),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .te_evt   (te_evt),
        .state    (st)
    );

    assign busy = (st == ST_SHIFT);

    sps_flags u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .pe_evt  (pe_evt),
        .te_evt  (te_evt),
        .err_clr (err_clr),
        .pe_en   (pe_en),
        .te_en   (te_en),
        .pe_flag (pe_flag),
        .te_flag (te_flag),
        .err_irq (err_irq)
    );
endmodule

// File: rtl/sps_checker.sv
module sps_checker
    import sps_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       rx_valid,
    input logic       pe_flag,
    input logic       te_flag,
    input logic       err_irq,
    input logic       pe_en,
    input logic       te_en,
    input logic       err_clr,
    input logic       pe_evt,
    input logic       te_evt,
    input sps_state_e st
);
    p_rxv_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_rxv_not_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !busy);

    p_busy_from_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(st) == ST_READY);

    p_pe_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pe_flag && !err_clr) |=> pe_flag);

    p_te_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (te_flag && !err_clr) |=> te_flag);

    p_pe_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clr && !pe_evt) |=> !pe_flag);

    p_te_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        te_evt |=> te_flag);

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!pe_en && !te_en) |-> !err_irq);
endmodule

bind spi_slave_err sps_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .rx_valid (rx_valid),
    .pe_flag  (pe_flag),
    .te_flag  (te_flag),
    .err_irq  (err_irq),
    .pe_en    (pe_en),
    .te_en    (te_en),
    .err_clr  (err_clr),
    .pe_evt   (pe_evt),
    .te_evt   (te_evt),
    .st       (st)
);

// File: tb/spi_slave_err_tb.sv
module spi_slave_err_tb;
    localparam int W  = 8;
    localparam int HP = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk_in = 1'b0, mosi_in = 1'b0, ssn_in = 1'b1;
    logic         miso_out;
    logic         tb_we = 1'b0;
    logic [W-1:0] tb_wdata = '0;
    logic [W-1:0] rx_data;
    logic         rx_valid, busy;
    logic         pe_en = 1'b0, te_en = 1'b0, err_clr = 1'b0;
    logic         pe_flag, te_flag, err_irq;

    int total = 0;
    int bad   = 0;
    int rxv_cnt = 0;
    bit done = 0;

    always #5 clk = ~clk;

    spi_slave_err #(.FRAME_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .mosi_in(mosi_in),
        .ssn_in(ssn_in), .miso_out(miso_out), .tb_we(tb_we), .tb_wdata(tb_wdata),
        .rx_data(rx_data), .rx_valid(rx_valid), .busy(busy), .pe_en(pe_en),
        .te_en(te_en), .err_clr(err_clr), .pe_flag(pe_flag), .te_flag(te_flag),
        .err_irq(err_irq)
    );

    always @(negedge clk) if (rst_n && rx_valid) rxv_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [W-1:0] v);
        tb_we = 1'b1; tb_wdata = v;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic xfer(input logic [W-1:0] mo, input logic mid_wr,
                        input logic [W-1:0] mid_val, output logic [W-1:0] mi);
        for (int i = W - 1; i >= 0; i--) begin
            mosi_in = mo[i];
            wait_clk(HP);
            if (i == W - 1) chk("R4 idle before frame", busy, 0);
            mi[i] = miso_out;
            sclk_in = 1'b1;
            wait_clk(HP);
            chk("R4 busy in frame", busy, 1);
            if (mid_wr && i == W / 2) wr(mid_val);
            sclk_in = 1'b0;
        end
        wait_clk(HP);
        chk("R4 busy after frame", busy, 0);
    endtask

    initial begin
        logic [W-1:0] mi, tx, rxw, prev;
        int c0;
        wait_clk(3);
        // R1 reset state
        chk("R1 pe", pe_flag, 0);
        chk("R1 te", te_flag, 0);
        chk("R1 irq", err_irq, 0);
        chk("R1 busy", busy, 0);
        chk("R1 rxv", rx_valid, 0);
        chk("R1 rx", rx_data, 0);
        chk("R1 miso", miso_out, 0);
        rst_n = 1'b1;
        wait_clk(3);
        chk("R1 miso after reset", miso_out, 0);

        pe_en = 1'b1; te_en = 1'b1;
        ssn_in = 1'b0;
        wait_clk(HP);
        // R2/R3 sweep with a fresh word each frame
        for (int k = 0; k < 8; k++) begin
            tx  = W'(k * 53 + 7);
            rxw = W'(k * 29 + 200);
            wr(tx);
            c0 = rxv_cnt;
            xfer(rxw, 1'b0, '0, mi);
            chk("R3 tx word", mi, tx);
            chk("R2 rx word", rx_data, rxw);
            chk("R2 one strobe", rxv_cnt - c0, 1);
            chk("R6 no te when fresh", te_flag, 0);
            chk("R7 no pe in clean frame", pe_flag, 0);
        end

        // R5 back-to-back
        wr(8'h5A);
        xfer(8'h96, 1'b1, 8'hC3, mi);
        chk("R3 first word", mi, 8'h5A);
        xfer(8'h3C, 1'b0, '0, mi);
        chk("R5 queued word", mi, 8'hC3);
        chk("R5 no te", te_flag, 0);
        prev = 8'h3C;

        // R6 stale buffer
        xfer(8'h71, 1'b0, '0, mi);
        chk("R6 resend rx word", mi, prev);
        chk("R6 te set", te_flag, 1);
        chk("R9 irq enabled", err_irq, 1);
        xfer(8'h0F, 1'b0, '0, mi);
        chk("R6 resend again", mi, 8'h71);

        // R9 mask, R8 sticky and clear
        te_en = 1'b0;
        wait_clk(2);
        chk("R9 irq masked", err_irq, 0);
        chk("R9 flag kept", te_flag, 1);
        wait_clk(20);
        chk("R8 still set", te_flag, 1);
        clr();
        wait_clk(1);
        chk("R8 cleared", te_flag, 0);

        // R7 phase window sweep, R10 abort
        ssn_in = 1'b1;
        wait_clk(HP);
        for (int d = -4; d <= 5; d++) begin
            ssn_in = 1'b0;
            wait_clk(HP);
            clr();
            wait_clk(HP);
            c0 = rxv_cnt;
            if (d < 0) begin
                mosi_in = ~mosi_in;
                wait_clk(-d);
                sclk_in = 1'b1;
            end else begin
                sclk_in = 1'b1;
                wait_clk(d);
                mosi_in = ~mosi_in;
            end
            wait_clk(10);
            chk($sformatf("R7 window d=%0d", d), pe_flag, (d >= -1 && d <= 2) ? 1 : 0);
            chk("R9 pe irq", err_irq, (d >= -1 && d <= 2) ? 1 : 0);
            sclk_in = 1'b0;
            wait_clk(HP);
            ssn_in = 1'b1;
            wait_clk(HP);
            chk("R10 busy after abort", busy, 0);
            chk("R10 no strobe", rxv_cnt - c0, 0);
            clr();
        end

        // R10 restart from bit one
        wr(8'h99);
        ssn_in = 1'b0;
        wait_clk(HP);
        for (int i = 0; i < 3; i++) begin
            mosi_in = i[0];
            wait_clk(HP); sclk_in = 1'b1;
            wait_clk(HP); sclk_in = 1'b0;
        end
        wait_clk(HP);
        ssn_in = 1'b1;
        wait_clk(HP);
        ssn_in = 1'b0;
        wr(8'hE7);
        wait_clk(HP);
        c0 = rxv_cnt;
        xfer(8'h4D, 1'b0, '0, mi);
        chk("R10 rx after abort", rx_data, 8'h4D);
        chk("R10 tx after abort", mi, 8'hE7);
        chk("R10 one strobe", rxv_cnt - c0, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule